// File: doc/BRIEF.md
# Dual 32-bit Timer

The block holds two independent up-counters, named low and high, behind a plain 32-bit register port with an address, a write strobe, write data and combinational read data. Each half has its own count register, its own period register and a 2-bit enable-mode field. A global control register chooses the operating mode of the pair and takes each half out of its held state. The counters advance on a clock-enable input named `tick`, which is normally a 24 MHz reference sampled into the system clock domain.

In the unchained mode, each half counts up to its own period and then restarts from zero. When it restarts it raises its own event output for one cycle. In continuous mode it keeps running after each restart. In one-shot mode it fires once, and the hardware then turns that half off. Software may load or clear a count register at any time, and may read it back as a free-running timestamp. A period of all ones gives the full counter range.

Top module: `dual_timer`

## Requirements
- R1: After reset every register reads 0 except the identity register at address 0x00, which always returns the constant `ID_VALUE`. Both event outputs are low.
- R2: Register addresses are: low count 0x10, high count 0x14, low period 0x18, high period 0x1C, control 0x20, global control 0x24. Written values read back. Count and period bits above `CNT_W` read 0. Unmapped addresses read 0.
- R3: Global control bits 3:2 hold the timer mode. Only the value 1 (two unchained counters) lets a half advance. Under any other value both counters hold their value.
- R4: Global control bit 0 releases the low half and bit 1 releases the high half. While its bit is 0, a half's counter is forced to 0 and writes to that counter have no effect. Its period and enable mode are kept.
- R5: A released half whose enable mode is 1 or 2 advances by exactly one on each cycle with `tick` high. It does not change on cycles with `tick` low.
- R6: In continuous mode (enable mode 2), a tick that finds the counter equal to its period loads 0. At that same clock edge the half's event output goes high for that one cycle.
- R7: In one-shot mode (enable mode 1), the matching tick loads 0 and pulses the event just as in R6. At the same edge the hardware sets that half's enable mode to 0, so the counter stays at 0 afterwards.
- R8: Enable mode 0, and the reserved value 3, freeze the counter at its present value without clearing it.
- R9: A software write to a count register takes priority over a tick in the same cycle. Counting resumes from the written value.
- R10: With the period at its maximum (all ones within `CNT_W`), the counter runs through every value and wraps from the maximum to 0 with an event.
- R11: The control register places the low enable mode in bits 7:6 and the high enable mode in bits 23:22. All other bits read 0. The two halves count, wrap and signal independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one count per high cycle |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_lo | output | 1 | One-cycle event from the low half |
| evt_hi | output | 1 | One-cycle event from the high half |

## Verification
The bench builds the block with `CNT_W` = 6, so a counter spans only 64 values. This small width makes it cheap to sweep every possible period, 0 through 63. The low half is swept in continuous mode over two full wraps per period. The high half is swept in one-shot mode past its single event. Expected counts and event cycles come from modular arithmetic on the tick number. The maximum period of 63 is part of the sweep, so the full-range wrap is reached directly. The remaining directed steps cover tick gating, freezing, write priority, timer-mode gating and per-half reset.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the dual timer.
// Assumes byte addresses and a 32-bit register port.
package tmr_pkg;
    localparam int DATA_W = 32;

    // Enable-mode encoding of each half.
    typedef enum logic [1:0] {
        EN_OFF  = 2'd0,
        EN_ONCE = 2'd1,
        EN_LOOP = 2'd2,
        EN_RSVD = 2'd3
    } en_mode_e;

    // Register byte addresses.
    localparam int A_ID     = 'h00;
    localparam int A_CNT_LO = 'h10;
    localparam int A_PRD_LO = 'h18;
    localparam int A_CTRL   = 'h20;
    localparam int A_GCTL   = 'h24;

    // Timer-mode value that runs the halves as two unchained counters.
    localparam logic [1:0] TM_UNCHAINED = 2'd1;

    // Bit position of a half's enable-mode field in the control register.
    localparam int MODE_LSB_BASE = 6;
    localparam int MODE_LSB_STEP = 16;
endpackage

// File: rtl/tmr_half.sv
// One counter half: count, period and enable-mode state, plus its event.
// Assumes the parent combines the release bit and the timer mode into 'run',
// and raises 'hold_clr' whenever the half is held in reset.
module tmr_half
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_clr,
    input  logic             run,
    input  logic             tick,
    input  logic             cnt_we,
    input  logic             prd_we,
    input  logic             mode_we,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [1:0]       mode_wval,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] prd,
    output logic [1:0]       mode,
    output logic             evt
);
    logic active;
    logic at_top;
    logic hit;

    // Decide whether this cycle advances the counter and whether it wraps.
    always_comb begin
        active = run && tick && (mode == EN_ONCE || mode == EN_LOOP);
        at_top = (cnt == prd);
        hit    = active && at_top && !cnt_we;
    end

    // Counter: a held half is cleared, a software write wins, otherwise count or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (hold_clr) cnt <= '0;
        else if (cnt_we)   cnt <= wr_val;
        else if (active)   cnt <= at_top ? '0 : cnt + 1'b1;
    end

    // Period register: written only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      prd <= '0;
        else if (prd_we) prd <= wr_val;
    end

    // Enable mode: a software write wins, and a one-shot turns itself off on its event.
    always_ff @(posedge clk) begin
        if (!rst_n)                   mode <= EN_OFF;
        else if (mode_we)             mode <= mode_wval;
        else if (hit && mode == EN_ONCE) mode <= EN_OFF;
    end

    // Event: a one-cycle pulse, high in the cycle that follows the wrapping edge.
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= 1'b0;
        else        evt <= hit;
    end
endmodule

// File: rtl/tmr_regdec.sv
// Register decode: write strobes and the read multiplexer for the timer.
// Assumes an exact match on the full address; unmapped reads return 0.
module tmr_regdec
    import tmr_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] ID_VALUE = 32'h7153_3232
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       we,
    input  logic [1:0][DATA_W-1:0]     cnt_rd,
    input  logic [1:0][DATA_W-1:0]     prd_rd,
    input  logic [DATA_W-1:0]          ctrl_rd,
    input  logic [DATA_W-1:0]          gctl_rd,
    output logic [1:0]                 we_cnt,
    output logic [1:0]                 we_prd,
    output logic                       we_ctrl,
    output logic                       we_gctl,
    output logic [DATA_W-1:0]          rdata
);
    // Write strobes, one per register.
    always_comb begin
        for (int i = 0; i < 2; i++) begin
            we_cnt[i] = we && (addr == ADDR_W'(A_CNT_LO + 4 * i));
            we_prd[i] = we && (addr == ADDR_W'(A_PRD_LO + 4 * i));
        end
        we_ctrl = we && (addr == ADDR_W'(A_CTRL));
        we_gctl = we && (addr == ADDR_W'(A_GCTL));
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(A_ID))   rdata = ID_VALUE;
        if (addr == ADDR_W'(A_CTRL)) rdata = ctrl_rd;
        if (addr == ADDR_W'(A_GCTL)) rdata = gctl_rd;
        for (int i = 0; i < 2; i++) begin
            if (addr == ADDR_W'(A_CNT_LO + 4 * i)) rdata = cnt_rd[i];
            if (addr == ADDR_W'(A_PRD_LO + 4 * i)) rdata = prd_rd[i];
        end
    end
endmodule

// File: rtl/dual_timer.sv
// Top level of the dual timer: global control, two counter halves, and register decode.
// Assumes 'tick' is already synchronous to clk; CNT_W must be between 2 and 32.
module dual_timer
    import tmr_pkg::*;
#(
    parameter int          CNT_W    = 32,
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] ID_VALUE = 32'h7153_3232
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              evt_lo,
    output logic              evt_hi
);
    localparam int GCTL_W = 4;

    logic [GCTL_W-1:0]          gctl_q;
    logic [1:0][CNT_W-1:0]      half_cnt;
    logic [1:0][CNT_W-1:0]      half_prd;
    logic [1:0][1:0]            half_mode;
    logic [1:0]                 half_evt;
    logic [1:0]                 we_cnt;
    logic [1:0]                 we_prd;
    logic                       we_ctrl;
    logic                       we_gctl;
    logic [1:0][DATA_W-1:0]     cnt_rd;
    logic [1:0][DATA_W-1:0]     prd_rd;
    logic [DATA_W-1:0]          ctrl_rd;
    logic [DATA_W-1:0]          gctl_rd;

    // Global control: timer mode in bits 3:2, per-half release in bits 1:0.
    always_ff @(posedge clk) begin
        if (!rst_n)       gctl_q <= '0;
        else if (we_gctl) gctl_q <= bus_wdata[GCTL_W-1:0];
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam int MLSB = MODE_LSB_BASE + MODE_LSB_STEP * h;

        tmr_half #(.CNT_W(CNT_W)) u_half (
            .clk       (clk),
            .rst_n     (rst_n),
            .hold_clr  (!gctl_q[h]),
            .run       (gctl_q[h] && (gctl_q[3:2] == TM_UNCHAINED)),
            .tick      (tick),
            .cnt_we    (we_cnt[h]),
            .prd_we    (we_prd[h]),
            .mode_we   (we_ctrl),
            .wr_val    (bus_wdata[CNT_W-1:0]),
            .mode_wval (bus_wdata[MLSB+1:MLSB]),
            .cnt       (half_cnt[h]),
            .prd       (half_prd[h]),
            .mode      (half_mode[h]),
            .evt       (half_evt[h])
        );

        // Zero-extend this half's count and period for reads.
        always_comb begin
            cnt_rd[h] = '0;
            prd_rd[h] = '0;
            cnt_rd[h][CNT_W-1:0] = half_cnt[h];
            prd_rd[h][CNT_W-1:0] = half_prd[h];
        end
    end

    // Build the read views of the control and global control registers.
    always_comb begin
        ctrl_rd = '0;
        for (int h = 0; h < 2; h++)
            ctrl_rd[MODE_LSB_BASE + MODE_LSB_STEP * h +: 2] = half_mode[h];
        gctl_rd = '0;
        gctl_rd[GCTL_W-1:0] = gctl_q;
    end

    tmr_regdec #(.ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_dec (
        .addr    (bus_addr),
        .we      (bus_we),
        .cnt_rd  (cnt_rd),
        .prd_rd  (prd_rd),
        .ctrl_rd (ctrl_rd),
        .gctl_rd (gctl_rd),
        .we_cnt  (we_cnt),
        .we_prd  (we_prd),
        .we_ctrl (we_ctrl),
        .we_gctl (we_gctl),
        .rdata   (bus_rdata)
    );

    assign evt_lo = half_evt[0];
    assign evt_hi = half_evt[1];
endmodule

// File: rtl/tmr_chk.sv
// Assertion checker for dual_timer, attached through bind below.
module tmr_chk #(
    parameter int          CNT_W    = 32,
    parameter int          ADDR_W   = 8,
    parameter logic [31:0] ID_VALUE = 32'h0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic [3:0]            gctl,
    input logic [1:0][CNT_W-1:0] cnt,
    input logic [1:0][CNT_W-1:0] prd,
    input logic [1:0][1:0]       mode,
    input logic [1:0]            evt,
    input logic [1:0]            we_cnt,
    input logic                  we_ctrl,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [31:0]           bus_rdata
);
    // R1
    id_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata == ID_VALUE));

    for (genvar h = 0; h < 2; h++) begin : g_chk
        // R4
        held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !gctl[h] |=> (cnt[h] == '0));

        // R3
        tmmode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gctl[h] && gctl[3:2] != 2'd1 && !we_cnt[h]) |=> $stable(cnt[h]));

        // R6
        evt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt[h] |-> (cnt[h] == '0));

        // R8
        freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gctl[h] && !we_cnt[h] && (mode[h] == 2'd0 || mode[h] == 2'd3))
            |=> (cnt[h] == $past(cnt[h])));

        // R7
        oneshot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gctl[h] && gctl[3:2] == 2'd1 && tick && mode[h] == 2'd1
             && cnt[h] == prd[h] && !we_cnt[h] && !we_ctrl)
            |=> (mode[h] == 2'd0 && evt[h]));
    end
endmodule

bind dual_timer tmr_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .gctl      (gctl_q),
    .cnt       (half_cnt),
    .prd       (half_prd),
    .mode      (half_mode),
    .evt       (half_evt),
    .we_cnt    (we_cnt),
    .we_ctrl   (we_ctrl),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/test_dual_timer.sv
// Self-checking bench for dual_timer built with a 6-bit counter width.
module test_dual_timer;
    localparam int          W    = 6;
    localparam int          MAXV = (1 << W) - 1;
    localparam logic [31:0] ID   = 32'h7153_3232;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        evt_lo, evt_hi;

    int vectors = 0;
    int fails = 0;

    always #10 clk = ~clk;

    dual_timer #(.CNT_W(W), .ADDR_W(8), .ID_VALUE(ID)) i_dual_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .evt_lo(evt_lo), .evt_hi(evt_hi)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #2 v = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 R2: reset values, identity, unmapped address
        rd(8'h00, v); chk("R1 id", v, ID);
        rd(8'h10, v); chk("R1 cnt_lo", v, 0);
        rd(8'h14, v); chk("R1 cnt_hi", v, 0);
        rd(8'h18, v); chk("R1 prd_lo", v, 0);
        rd(8'h1C, v); chk("R1 prd_hi", v, 0);
        rd(8'h20, v); chk("R1 ctrl", v, 0);
        rd(8'h24, v); chk("R1 gctl", v, 0);
        rd(8'h04, v); chk("R2 unmapped", v, 0);
        chk("R1 evts", {evt_hi, evt_lo}, 0);

        // R2: read-back and width truncation
        wr(8'h24, 32'h7); rd(8'h24, v); chk("R2 gctl", v, 32'h7);
        wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, v); chk("R2 prd_hi trunc", v, MAXV);
        wr(8'h18, 32'h15); rd(8'h18, v); chk("R2 prd_lo", v, 32'h15);

        // R5 R6 R10: periodic sweep of every period on the low half
        for (int p = 0; p <= MAXV; p++) begin
            wr(8'h20, 32'h0);
            wr(8'h10, 32'h0);
            wr(8'h18, p);
            wr(8'h20, 32'h2 << 6);
            @(negedge clk); addr = 8'h10; tick = 1'b1;
            for (int k = 1; k <= 2 * (p + 1) + 1; k++) begin
                @(posedge clk); #2;
                chk(p == MAXV ? "R10 full-range count" : "R6 periodic count", rdata, k % (p + 1));
                chk("R6 periodic event", evt_lo, (k % (p + 1)) == 0);
            end
            @(negedge clk); tick = 1'b0;
        end
        wr(8'h20, 32'h0);

        // R7 R11: one-shot sweep on the high half, low half idle
        for (int p = 0; p <= MAXV; p++) begin
            wr(8'h14, 32'h0);
            wr(8'h1C, p);
            wr(8'h20, 32'h1 << 22);
            @(negedge clk); addr = 8'h14; tick = 1'b1;
            for (int k = 1; k <= p + 3; k++) begin
                @(posedge clk); #2;
                chk("R7 one-shot count", rdata, (k <= p) ? k : 0);
                chk("R7 one-shot event", evt_hi, k == p + 1);
                chk("R11 low idle", evt_lo, 0);
            end
            @(negedge clk); tick = 1'b0;
            rd(8'h20, v); chk("R7 mode cleared", v, 0);
        end

        // R5: tick gating
        wr(8'h10, 32'h0); wr(8'h18, MAXV); wr(8'h20, 32'h2 << 6);
        repeat (5) @(negedge clk);
        rd(8'h10, v); chk("R5 no tick", v, 0);
        ticks(5);
        rd(8'h10, v); chk("R5 single ticks", v, 5);

        // R8 R11: freeze with mode 0 and with reserved mode 3
        wr(8'h20, 32'h0); ticks(4);
        rd(8'h10, v); chk("R8 mode0 freeze", v, 5);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, v); chk("R11 ctrl fields", v, 32'h00C0_00C0);
        ticks(4);
        rd(8'h10, v); chk("R8 mode3 freeze", v, 5);

        // R9: write wins over a simultaneous tick
        wr(8'h20, 32'h2 << 6);
        @(negedge clk); addr = 8'h10; we = 1'b1; wdata = 32'd10; tick = 1'b1;
        @(posedge clk); #2; chk("R9 write priority", rdata, 10);
        @(negedge clk); we = 1'b0;
        @(posedge clk); #2; chk("R9 resume", rdata, 11);
        @(negedge clk); tick = 1'b0;

        // R3: timer mode other than unchained holds the counters
        wr(8'h24, 32'hB); ticks(3);
        rd(8'h10, v); chk("R3 mode2 hold", v, 11);
        wr(8'h24, 32'h3); ticks(3);
        rd(8'h10, v); chk("R3 mode0 hold", v, 11);

        // R4 R11: low half held in reset, high half runs
        wr(8'h24, 32'h6);
        rd(8'h10, v); chk("R4 held clear", v, 0);
        wr(8'h10, 32'd20);
        rd(8'h10, v); chk("R4 write ignored", v, 0);
        rd(8'h18, v); chk("R4 period kept", v, MAXV);
        wr(8'h14, 32'h0); wr(8'h1C, MAXV);
        wr(8'h20, (32'h2 << 6) | (32'h2 << 22));
        ticks(3);
        rd(8'h14, v); chk("R11 high independent", v, 3);
        rd(8'h10, v); chk("R4 low still held", v, 0);
        rd(8'h20, v); chk("R4 mode kept", v, 32'h0080_0080);
        wr(8'h24, 32'h7); ticks(2);
        rd(8'h10, v); chk("R4 released counts", v, 2);
        rd(8'h14, v); chk("R11 high continues", v, 5);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule